// File: doc/BRIEF.md
# Multiplexed-Bus Nibble RAM Node

This block is the memory side of a narrow 4-bit multiplexed processor bus. A processor sends every instruction cycle over four wires, one nibble per phase. The block follows those phases from a sync pulse, without help from anyone else. It snoops the two opcode nibbles of each cycle and reacts to two kinds of instruction. The first is an address-transfer instruction, which delivers an 8-bit address in the last execute phases. The second is a memory operation, issued in a later cycle, which reads or writes one nibble at that address.

Storage holds 320 bits. There are four registers, and each register has sixteen main characters and four status characters of 4 bits each. Up to four nodes share one bank command line. A 2-bit strap input tells them apart: a node answers only when the top two bits of the transferred address match its strap. The bus is split into an input nibble, an output nibble and an output enable, so that a tristate buffer can sit at the chip pad. The node raises the enable only while it returns read data.

Top module: `mux_bus_nibble_ram`

## Requirements
- R1: Synchronous active-high reset leaves `bus_oe` low and the node deselected. A read operation issued before any accepted address transfer produces no bus drive.
- R2: The clock after a clock with `sync` high is phase A1. Phases then advance one per clock through A1, A2, A3, M1, M2, X1, X2, X3 and wrap to A1. A new `sync` restarts the sequence at A1 from any phase.
- R3: An address transfer is an instruction whose M1 nibble is 0x2 and whose M2 nibble is odd. Its address high nibble is taken in X2 and its low nibble in X3, but only if `cm` is high in X2. Any other instruction, and a transfer seen with `cm` low, leaves the latched address and the selection unchanged.
- R4: In an accepted transfer, high-nibble bits [3:2] are compared with `strap`, and the node is selected exactly when they match. High-nibble bits [1:0] pick the register, and the low nibble picks main character 0 to 15.
- R5: Write-character opcode 0xE0 (M1 nibble 0xE, M2 nibble 0x0) stores the X2 bus nibble at the latched register and character.
- R6: Read-character opcode 0xE9 drives the stored nibble on `bus_o` with `bus_oe` high during X2 only.
- R7: Status-write opcodes 0xE4 to 0xE7 store the X2 nibble in status character k = opcode bits [1:0] of the latched register. Status characters are separate from the main characters.
- R8: Status-read opcodes 0xEC to 0xEF drive status character k = opcode bits [1:0] of the latched register during X2.
- R9: A memory operation takes effect only if the node is selected and `cm` is high during that instruction's M2. Other opcodes with M1 nibble 0xE do nothing. Without effect, nothing is stored and `bus_oe` stays low.
- R10: The latched address persists across any number of instruction cycles and operations until the next accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Cycle-start marker; the next clock is A1 |
| bus_i | input | 4 | Nibble seen on the shared bus |
| bus_o | output | 4 | Nibble driven during a read X2, zero otherwise |
| bus_oe | output | 1 | High while the node drives the bus |
| cm | input | 1 | Bank command line for this node's bank |
| strap | input | 2 | Chip position of this node within its bank |

## Verification
The bench fills every main and status character through the bus, using a value pattern that differs by register, character and index. It then reads all of them back, so any aliasing between the two arrays or wrong address bits shows up. Selection is tested by sweeping the strap across all four positions and addressing both the matching chip and a wrong one. Negative patterns each leave a known nibble in place that a following read must return unchanged: a transfer with the bank line low, an even second opcode nibble, a mismatched chip, `cm` low in M2, and an unused memory opcode. A cycle aborted by an early sync checks that phase tracking restarts cleanly.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  typedef enum logic [2:0] {
    PH_A1 = 3'd0, PH_A2 = 3'd1, PH_A3 = 3'd2, PH_M1 = 3'd3,
    PH_M2 = 3'd4, PH_X1 = 3'd5, PH_X2 = 3'd6, PH_X3 = 3'd7
  } phase_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_XFER, OP_WCHR, OP_RCHR, OP_WSTA, OP_RSTA
  } op_t;

  localparam logic [3:0] GRP_XFER = 4'h2;
  localparam logic [3:0] GRP_MEM  = 4'hE;

  function automatic op_t decode_op(input logic [3:0] hi, input logic [3:0] lo);
    op_t r;
    r = OP_NONE;
    if (hi == GRP_XFER && lo[0]) r = OP_XFER;
    else if (hi == GRP_MEM) begin
      if (lo == 4'h0)              r = OP_WCHR;
      else if (lo == 4'h9)         r = OP_RCHR;
      else if (lo[3:2] == 2'b01)   r = OP_WSTA;
      else if (lo[3:2] == 2'b11)   r = OP_RSTA;
    end
    return r;
  endfunction
endpackage

// File: rtl/nbr_phase.sv
module nbr_phase
  import nbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sync,
  output phase_t phase,
  output logic   valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_X3;
      valid <= 1'b0;
    end else if (sync) begin
      phase <= PH_A1;
      valid <= 1'b1;
    end else if (valid) begin
      phase <= phase_t'(phase + 3'd1);
    end
  end
endmodule

// File: rtl/nbr_decode.sv
module nbr_decode
  import nbr_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             valid,
  input  phase_t           phase,
  input  logic [NIB_W-1:0] bus_i,
  input  logic             cm,
  output op_t              op_q,
  output logic             cm_m2_q,
  output logic [1:0]       idx_q
);
  logic [3:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      op_q    <= OP_NONE;
      cm_m2_q <= 1'b0;
      idx_q   <= '0;
    end else if (sync) begin
      op_q    <= OP_NONE;
      cm_m2_q <= 1'b0;
    end else if (valid) begin
      if (phase == PH_M1) hi_q <= bus_i[3:0];
      if (phase == PH_M2) begin
        op_q    <= decode_op(hi_q, bus_i[3:0]);
        cm_m2_q <= cm;
        idx_q   <= bus_i[1:0];
      end
    end
  end
endmodule

// File: rtl/nbr_addr_latch.sv
module nbr_addr_latch
  import nbr_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int REG_W  = 2,
  parameter int CHR_W  = 4,
  localparam int CHIP_W = NIB_W - REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  phase_t            phase,
  input  op_t               op,
  input  logic              cm,
  input  logic [NIB_W-1:0]  bus_i,
  input  logic [CHIP_W-1:0] strap,
  output logic              sel_q,
  output logic [REG_W-1:0]  reg_q,
  output logic [CHR_W-1:0]  chr_q
);
  logic take_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      reg_q  <= '0;
      chr_q  <= '0;
      take_q <= 1'b0;
    end else if (valid) begin
      if (phase == PH_X2) begin
        take_q <= 1'b0;
        if (op == OP_XFER && cm) begin
          sel_q  <= (bus_i[NIB_W-1 -: CHIP_W] == strap);
          reg_q  <= bus_i[REG_W-1:0];
          take_q <= 1'b1;
        end
      end
      if (phase == PH_X3) begin
        if (take_q) chr_q <= bus_i[CHR_W-1:0];
        take_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nbr_store.sv
module nbr_store #(
  parameter int W     = 4,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mux_bus_nibble_ram.sv
module mux_bus_nibble_ram
  import nbr_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int N_REGS  = 4,
  parameter int N_CHARS = 16,
  parameter int N_STAT  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sync,
  input  logic [NIB_W-1:0]                 bus_i,
  output logic [NIB_W-1:0]                 bus_o,
  output logic                             bus_oe,
  input  logic                             cm,
  input  logic [NIB_W-$clog2(N_REGS)-1:0]  strap
);
  localparam int REG_W  = $clog2(N_REGS);
  localparam int CHR_W  = $clog2(N_CHARS);
  localparam int STA_W  = $clog2(N_STAT);
  localparam int MAIN_D = N_REGS * N_CHARS;
  localparam int STAT_D = N_REGS * N_STAT;

  phase_t           ph_cur;
  logic             ph_valid;
  op_t              op_q;
  logic             cm_m2_q;
  logic [1:0]       idx_q;
  logic             sel_q;
  logic [REG_W-1:0] reg_q;
  logic [CHR_W-1:0] chr_q;

  nbr_phase u_phase (
    .clk(clk), .rst(rst), .sync(sync), .phase(ph_cur), .valid(ph_valid)
  );

  nbr_decode #(.NIB_W(NIB_W)) u_dec (
    .clk(clk), .rst(rst), .sync(sync), .valid(ph_valid), .phase(ph_cur),
    .bus_i(bus_i), .cm(cm), .op_q(op_q), .cm_m2_q(cm_m2_q), .idx_q(idx_q)
  );

  nbr_addr_latch #(.NIB_W(NIB_W), .REG_W(REG_W), .CHR_W(CHR_W)) u_lat (
    .clk(clk), .rst(rst), .valid(ph_valid), .phase(ph_cur), .op(op_q),
    .cm(cm), .bus_i(bus_i), .strap(strap),
    .sel_q(sel_q), .reg_q(reg_q), .chr_q(chr_q)
  );

  logic go, at_x1, at_x2;
  logic main_we, main_re, stat_we, stat_re;
  assign go    = ph_valid && sel_q && cm_m2_q;
  assign at_x1 = (ph_cur == PH_X1);
  assign at_x2 = (ph_cur == PH_X2);

  assign main_we = go && at_x2 && (op_q == OP_WCHR);
  assign main_re = go && at_x1 && (op_q == OP_RCHR);
  assign stat_we = go && at_x2 && (op_q == OP_WSTA);
  assign stat_re = go && at_x1 && (op_q == OP_RSTA);

  logic [NIB_W-1:0] main_rd, stat_rd;

  nbr_store #(.W(NIB_W), .DEPTH(MAIN_D)) u_main (
    .clk(clk), .we(main_we), .waddr({reg_q, chr_q}), .wdata(bus_i),
    .re(main_re), .raddr({reg_q, chr_q}), .rdata(main_rd)
  );

  nbr_store #(.W(NIB_W), .DEPTH(STAT_D)) u_stat (
    .clk(clk), .we(stat_we), .waddr({reg_q, idx_q[STA_W-1:0]}), .wdata(bus_i),
    .re(stat_re), .raddr({reg_q, idx_q[STA_W-1:0]}), .rdata(stat_rd)
  );

  logic oe_q, from_stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q        <= 1'b0;
      from_stat_q <= 1'b0;
    end else begin
      oe_q <= main_re || stat_re;
      if (main_re || stat_re) from_stat_q <= stat_re;
    end
  end

  assign bus_oe = oe_q;
  assign bus_o  = oe_q ? (from_stat_q ? stat_rd : main_rd) : '0;
endmodule

// File: rtl/nbr_chk.sv
module nbr_chk
  import nbr_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   sync,
  input logic   valid,
  input phase_t phase,
  input logic   sel,
  input logic   bus_oe
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!bus_oe && !sel));
  a_r2_sync_to_a1: assert property (@(posedge clk) disable iff (rst)
    sync |=> (phase == PH_A1));
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (valid && !sync) |=> (phase == $past(phase) + 3'd1));
  a_r6_oe_only_x2: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (phase == PH_X2));
  a_r6_oe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bus_oe |=> !bus_oe);
  a_r9_oe_needs_sel: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> sel);
  a_r4_sel_moves_after_x2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel) |-> ($past(phase) == PH_X2));
endmodule

bind mux_bus_nibble_ram nbr_chk u_chk (
  .clk(clk), .rst(rst), .sync(sync), .valid(ph_valid),
  .phase(ph_cur), .sel(sel_q), .bus_oe(bus_oe)
);

// File: tb/mux_bus_nibble_ram_tb.sv
`timescale 1ns/1ps
module mux_bus_nibble_ram_tb;
  logic clk = 1'b0;
  logic rst, sync, cm;
  logic [3:0] bus_i, bus_o;
  logic bus_oe;
  logic [1:0] strap;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_nibble_ram u_dut (
    .clk(clk), .rst(rst), .sync(sync), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe(bus_oe), .cm(cm), .strap(strap)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full instruction cycle; phase p is current at the p-th negedge
  task automatic instr(input logic [3:0] hi, input logic [3:0] lo,
                       input logic cm_m2, input logic cm_x2,
                       input logic [3:0] x2n, input logic [3:0] x3n,
                       output logic seen, output logic [3:0] dat,
                       output logic stray);
    seen = 1'b0; dat = 4'h0; stray = 1'b0;
    @(negedge clk); sync = 1'b1; bus_i = 4'h0; cm = 1'b0;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      if (p == 6) begin seen = bus_oe; dat = bus_o; end
      else if (bus_oe) stray = 1'b1;
      sync  = 1'b0;
      bus_i = (p == 3) ? hi : (p == 4) ? lo : (p == 6) ? x2n : (p == 7) ? x3n : 4'h0;
      cm    = (p == 4) ? cm_m2 : (p == 6) ? cm_x2 : 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic cmx, input logic [3:0] lo);
    logic s, st; logic [3:0] d;
    instr(4'h2, lo, 1'b0, cmx, a[7:4], a[3:0], s, d, st);
  endtask

  task automatic wr(input logic [3:0] lo, input logic cmm, input logic [3:0] v);
    logic s, st; logic [3:0] d;
    instr(4'hE, lo, cmm, 1'b0, v, 4'h0, s, d, st);
  endtask

  task automatic rd(input string req, input logic [3:0] lo, input logic cmm,
                    input logic exp_drive, input logic [3:0] exp_val);
    logic s, st; logic [3:0] d;
    instr(4'hE, lo, cmm, 1'b0, 4'h0, 4'h0, s, d, st);
    chk({req, " drive"}, {7'd0, s}, {7'd0, exp_drive});
    chk({req, " stray"}, {7'd0, st}, 8'd0);
    if (exp_drive) chk({req, " data"}, {4'd0, d}, {4'd0, exp_val});
  endtask

  function automatic logic [3:0] fm(input int r, input int c);
    return 4'((r * 5 + c * 3 + 1) % 16);
  endfunction
  function automatic logic [3:0] fs(input int r, input int i);
    return 4'((r * 7 + i + 9) % 16);
  endfunction

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; sync = 1'b0; cm = 1'b0; bus_i = 4'h0; strap = 2'd2;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", {7'd0, bus_oe}, 8'd0);
    rst = 1'b0;
    rd("R1 read before transfer", 4'h9, 1'b1, 1'b0, 4'h0);

    // R5 R4: fill all main characters of chip 2
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) begin
        xfer({2'd2, 2'(r), 4'(c)}, 1'b1, 4'h1);
        wr(4'h0, 1'b1, fm(r, c));
      end
    // R7: fill status characters
    for (int r = 0; r < 4; r++) begin
      xfer({2'd2, 2'(r), 4'h0}, 1'b1, 4'h3);
      for (int i = 0; i < 4; i++) wr(4'(4 + i), 1'b1, fs(r, i));
    end
    // R6 R4: read back every main character
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) begin
        xfer({2'd2, 2'(r), 4'(c)}, 1'b1, 4'h1);
        rd("R6 R4 main readback", 4'h9, 1'b1, 1'b1, fm(r, c));
      end
    // R8: read back status characters
    for (int r = 0; r < 4; r++) begin
      xfer({2'd2, 2'(r), 4'h7}, 1'b1, 4'hF);
      for (int i = 0; i < 4; i++)
        rd("R8 status readback", 4'(12 + i), 1'b1, 1'b1, fs(r, i));
    end

    // R10: address persists over several operations
    xfer({2'd2, 2'd1, 4'd5}, 1'b1, 4'h1);
    rd("R10 first read", 4'h9, 1'b1, 1'b1, fm(1, 5));
    wr(4'h0, 1'b1, 4'hA);
    rd("R10 after write", 4'h9, 1'b1, 1'b1, 4'hA);
    rd("R10 again", 4'h9, 1'b1, 1'b1, 4'hA);

    // R3: transfer with cm low is ignored
    xfer({2'd2, 2'd3, 4'd0}, 1'b0, 4'h1);
    rd("R3 cm low transfer", 4'h9, 1'b1, 1'b1, 4'hA);
    // R3: even second nibble is not a transfer
    xfer({2'd2, 2'd3, 4'd0}, 1'b1, 4'h2);
    rd("R3 even opcode", 4'h9, 1'b1, 1'b1, 4'hA);

    // R4: mismatched chip deselects; write ignored
    xfer({2'd1, 2'd1, 4'd5}, 1'b1, 4'h1);
    wr(4'h0, 1'b1, 4'h3);
    rd("R4 wrong chip read", 4'h9, 1'b1, 1'b0, 4'h0);
    xfer({2'd2, 2'd1, 4'd5}, 1'b1, 4'h1);
    rd("R4 wrong chip write ignored", 4'h9, 1'b1, 1'b1, 4'hA);

    // R9: cm low in M2
    rd("R9 cm low read", 4'h9, 1'b0, 1'b0, 4'h0);
    wr(4'h0, 1'b0, 4'h5);
    rd("R9 cm low write ignored", 4'h9, 1'b1, 1'b1, 4'hA);
    wr(4'h6, 1'b0, 4'h5);
    rd("R9 cm low status write ignored", 4'hE, 1'b1, 1'b1, fs(1, 2));
    // R9: unused memory opcode
    begin
      logic s, st; logic [3:0] d;
      instr(4'hE, 4'h1, 1'b1, 1'b0, 4'h7, 4'h0, s, d, st);
      chk("R9 unused opcode drive", {7'd0, s | st}, 8'd0);
    end
    rd("R9 unused opcode no store", 4'h9, 1'b1, 1'b1, 4'hA);

    // R2: cycle cut short by an early sync
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0; bus_i = 4'hE;
    @(negedge clk); bus_i = 4'h0; cm = 1'b1;
    @(negedge clk); cm = 1'b0;
    rd("R2 restart", 4'h9, 1'b1, 1'b1, 4'hA);
    xfer({2'd2, 2'd2, 4'd9}, 1'b1, 4'h1);
    rd("R2 restart transfer", 4'h9, 1'b1, 1'b1, fm(2, 9));

    // R4: strap sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      xfer({2'(s), 2'd0, 4'd0}, 1'b1, 4'h1);
      rd("R4 strap match", 4'h9, 1'b1, 1'b1, fm(0, 0));
      xfer({2'(s + 1), 2'd0, 4'd0}, 1'b1, 4'h1);
      rd("R4 strap mismatch", 4'h9, 1'b1, 1'b0, 4'h0);
    end

    // R1: reset deselects
    strap = 2'd2;
    xfer({2'd2, 2'd0, 4'd0}, 1'b1, 4'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 oe after reset", {7'd0, bus_oe}, 8'd0);
    rd("R1 deselected after reset", 4'h9, 1'b1, 1'b0, 4'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    done = 1'b1;
    $finish;
  end
endmodule